// File: doc/BRIEF.md
# Shadowed SRAM with Nonvolatile Backup

This block models a 512-location, 8-bit static memory that has a nonvolatile shadow array behind it, bit for bit. Four active-low control inputs select the operation. The controls are chip select (`ce_n`), write strobe (`we_n`), shadow strobe (`nv_n`) and output enable (`oe_n`). Host reads and writes go to the working array. Two whole-array transfers move data between the arrays. A restore copies the shadow array into the working array. A save copies the working array into the shadow array. Each transfer moves one location per clock and holds `busy` high until it is done.

A transfer starts only when its control combination has been held for `MIN_PULSE` consecutive clocks. The default of 4 clocks corresponds to 20 ns at the bench clock. A transfer starts once per hold and does not start again until the combination is released. A save also needs at least one host write since the last save or since power-up. A digital `supply_ok` input stands in for supply sensing. While it is low, every function is inhibited. When it rises, a restore runs whatever the controls are. The shadow array keeps its contents while `supply_ok` is low.

The controller has five states. OFF waits for supply. IDLE serves host accesses. RESTORE and SAVE copy one location per clock. SETTLE models the long save time with `SAVE_HOLD` extra cycles. Transitions:
- OFF to RESTORE when supply is good.
- IDLE to RESTORE when a restore strobe is accepted.
- IDLE to SAVE when a save strobe is accepted and a host write is pending.
- RESTORE to IDLE after the last location.
- SAVE to SETTLE (or to IDLE if `SAVE_HOLD` is 0) after the last location.
- SETTLE to IDLE after `SAVE_HOLD` cycles.
- Any state to OFF when supply drops.

Top module: `nvsram_shadow`

## Requirements
- R1: The working array holds 2^9 = 512 bytes addressed by `addr`. With (ce_n,we_n,nv_n) = (0,0,1), and `oe_n` either value, `wdata` is written to `addr` on the clock edge.
- R2: `rdata_oe` is 1, and `rdata` shows the byte at `addr` in the same cycle, only for (ce_n,we_n,nv_n,oe_n) = (0,1,1,0). For every other combination `rdata_oe` is 0.
- R3: A restore strobe is (ce_n,we_n,nv_n,oe_n) = (0,1,0,0) held for MIN_PULSE clocks. It copies all 512 shadow bytes into the working array, with `busy` high for exactly 512 cycles.
- R4: A save strobe is (0,0,0,1) held for MIN_PULSE clocks. It copies all 512 working bytes into the shadow array, with `busy` high for 512 + SAVE_HOLD cycles.
- R5: A save strobe is refused, and `busy` stays 0, unless a host write has occurred since the last save or since supply came up.
- R6: The combination (0,0,0,0) has no effect: no write, no transfer, `busy` stays 0. In particular, oe_n low blocks a save.
- R7: A restore or save combination held for fewer than MIN_PULSE clocks starts nothing.
- R8: A strobe held for longer than a whole transfer starts only one transfer. It cannot start another until it is released.
- R9: While `supply_ok` is 0, writes are dropped, `rdata_oe` is 0 and `busy` is 0. When `supply_ok` rises, a restore runs whatever the controls are, and the shadow contents survive the supply loss.
- R10: While `busy` is 1, host writes are dropped and `rdata_oe` is 0.
- R11: The combination (0,1,0,1) and any combination with ce_n = 1 change nothing and start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state |
| supply_ok | input | 1 | Supply good. Low inhibits all functions, and its rise triggers a restore |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| nv_n | input | 1 | Shadow transfer strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not driving |
| rdata_oe | output | 1 | Output driver enable (tri-state control) |
| busy | output | 1 | Transfer in progress |

## Verification
Reads are combinational, so the bench checks `rdata` and `rdata_oe` one nanosecond after it changes the inputs at a falling edge. A write takes effect at the next rising edge and is read back at a later falling edge. A strobe is accepted at the MIN_PULSE-th rising edge of the hold, so `busy` is first sampled at the falling edge that follows that edge. It then counts `busy` at every falling edge, and the count must be exactly 512 for a restore and 512 + SAVE_HOLD for a save. For a supply rise, the first `busy` sample is taken one falling edge after `supply_ok` is raised. Refused or filtered strobes are confirmed by `busy` staying 0 across the hold and by reading back the affected bytes afterwards.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    // Operation decoded from the four active-low controls
    typedef enum logic [2:0] {
        M_DESELECT,
        M_READ,
        M_WRITE,
        M_RESTORE,
        M_SAVE,
        M_OUT_OFF,
        M_NOP,
        M_ILLEGAL
    } nvs_mode_e;

    // Transfer controller states
    typedef enum logic [2:0] {
        S_OFF,
        S_IDLE,
        S_RESTORE,
        S_SAVE,
        S_SETTLE
    } nvs_state_e;

endpackage

// File: rtl/nvs_mode_decode.sv
module nvs_mode_decode
    import nvs_pkg::*;
(
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      nv_n,
    input  logic      oe_n,
    output nvs_mode_e mode
);

    always_comb begin
        if (ce_n) begin
            mode = M_DESELECT;
        end else if (!we_n && nv_n) begin
            mode = M_WRITE;                       // output enable is don't-care
        end else if (we_n && nv_n) begin
            mode = oe_n ? M_OUT_OFF : M_READ;
        end else if (we_n && !nv_n) begin
            mode = oe_n ? M_NOP : M_RESTORE;
        end else begin
            mode = oe_n ? M_SAVE : M_ILLEGAL;     // low output enable blocks save
        end
    end

endmodule

// File: rtl/nvs_pulse_qual.sv
module nvs_pulse_qual #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,     // qualifying combination present
    input  logic enable,   // counting allowed (controller idle)
    output logic fire      // one-cycle start request
);

    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

    logic [CW-1:0] held_cnt;
    logic          spent;

    assign fire = qual && enable && !spent && (held_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_cnt <= '0;
            spent    <= 1'b0;
        end else if (!qual) begin
            held_cnt <= '0;
            spent    <= 1'b0;
        end else begin
            if (fire)
                spent <= 1'b1;
            if (enable && held_cnt != LAST)
                held_cnt <= held_cnt + 1'b1;
        end
    end

    // R8: a start request lasts a single cycle
    p_single_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    if (MIN_PULSE > 1) begin : g_width_chk
        // R7: a request needs the combination present in the previous cycle too
        p_min_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
            fire |-> $past(qual));
    end

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nvs_xfer_ctrl.sv
module nvs_xfer_ctrl
    import nvs_pkg::*;
#(
    parameter int AW        = 9,
    parameter int SAVE_HOLD = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          restore_fire,
    input  logic          save_fire,
    input  logic          host_wr,
    output logic [AW-1:0] ptr,
    output logic          ram_copy_we,
    output logic          nv_copy_we,
    output logic          busy,
    output logic          idle
);

    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};
    localparam int HW = $clog2(SAVE_HOLD + 2);
    localparam logic [HW-1:0] HOLD_LAST = HW'((SAVE_HOLD > 0) ? SAVE_HOLD - 1 : 0);

    nvs_state_e    state, state_nx;
    logic [HW-1:0] hold_cnt;
    logic          dirty;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:     if (supply_ok) state_nx = S_RESTORE;
            S_IDLE: begin
                if (restore_fire)            state_nx = S_RESTORE;
                else if (save_fire && dirty) state_nx = S_SAVE;
            end
            S_RESTORE: if (ptr == LAST_ADDR) state_nx = S_IDLE;
            S_SAVE:    if (ptr == LAST_ADDR) state_nx = (SAVE_HOLD == 0) ? S_IDLE : S_SETTLE;
            S_SETTLE:  if (hold_cnt == HOLD_LAST) state_nx = S_IDLE;
            default:   state_nx = S_OFF;
        endcase
        if (!supply_ok)
            state_nx = S_OFF;
    end

    // State register and datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_OFF;
            ptr      <= '0;
            hold_cnt <= '0;
            dirty    <= 1'b0;
        end else begin
            state    <= state_nx;
            ptr      <= (state == S_RESTORE || state == S_SAVE) ? ptr + 1'b1 : '0;
            hold_cnt <= (state == S_SETTLE) ? hold_cnt + 1'b1 : '0;
            if (state == S_OFF || state_nx == S_SAVE)
                dirty <= 1'b0;
            else if (host_wr)
                dirty <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ram_copy_we = 1'b0;
        nv_copy_we  = 1'b0;
        busy        = 1'b0;
        idle        = 1'b0;
        unique case (state)
            S_OFF:     ;
            S_IDLE:    idle = 1'b1;
            S_RESTORE: begin ram_copy_we = 1'b1; busy = 1'b1; end
            S_SAVE:    begin nv_copy_we  = 1'b1; busy = 1'b1; end
            S_SETTLE:  busy = 1'b1;
            default:   ;
        endcase
    end

    // R5: a save begins only while a host write is pending
    p_save_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_copy_we) |-> $past(dirty));

    // R9: loss of supply shuts everything down on the next edge
    p_supply_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!busy && !idle));

    // R9: supply rising in the off state begins a restore
    p_powerup_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF && supply_ok) |=> ram_copy_we);

    // R3: a restore never overlaps a save
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_copy_we && nv_copy_we));

endmodule

// File: rtl/nvsram_shadow.sv
module nvsram_shadow
    import nvs_pkg::*;
#(
    parameter int AW        = 9,
    parameter int DW        = 8,
    parameter int MIN_PULSE = 4,
    parameter int SAVE_HOLD = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          nv_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe,
    output logic          busy
);

    nvs_mode_e     mode;
    logic          idle;
    logic          restore_fire, save_fire;
    logic          ram_copy_we, nv_copy_we;
    logic [AW-1:0] ptr;
    logic          host_we, rd_en, live;

    logic          ram_we;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [DW-1:0] ram_wdata, ram_rdata, nv_rdata;

    nvs_mode_decode u_decode (
        .ce_n (ce_n),
        .we_n (we_n),
        .nv_n (nv_n),
        .oe_n (oe_n),
        .mode (mode)
    );

    assign live    = supply_ok && idle;
    assign host_we = live && (mode == M_WRITE);
    assign rd_en   = live && (mode == M_READ);

    nvs_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_restore_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual   (mode == M_RESTORE),
        .enable (live),
        .fire   (restore_fire)
    );

    nvs_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_save_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual   (mode == M_SAVE),
        .enable (live),
        .fire   (save_fire)
    );

    nvs_xfer_ctrl #(.AW(AW), .SAVE_HOLD(SAVE_HOLD)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .restore_fire (restore_fire),
        .save_fire    (save_fire),
        .host_wr      (host_we),
        .ptr          (ptr),
        .ram_copy_we  (ram_copy_we),
        .nv_copy_we   (nv_copy_we),
        .busy         (busy),
        .idle         (idle)
    );

    assign ram_we    = host_we || ram_copy_we;
    assign ram_waddr = ram_copy_we ? ptr : addr;
    assign ram_wdata = ram_copy_we ? nv_rdata : wdata;
    assign ram_raddr = nv_copy_we ? ptr : addr;

    nvs_array #(.AW(AW), .DW(DW)) u_work (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    nvs_array #(.AW(AW), .DW(DW)) u_shadow (
        .clk   (clk),
        .we    (nv_copy_we),
        .waddr (ptr),
        .wdata (ram_rdata),
        .raddr (ptr),
        .rdata (nv_rdata)
    );

    assign rdata_oe = rd_en;
    assign rdata    = rd_en ? ram_rdata : '0;

    // R2: output driver only on a read combination
    p_drive_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!ce_n && we_n && nv_n && !oe_n));

    // R10: no output drive during a transfer
    p_quiet_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rdata_oe);

    // R9: no output drive without supply
    p_quiet_no_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !rdata_oe);

endmodule

// File: tb/tb_nvsram_shadow.sv
`timescale 1ns/1ps
module tb_nvsram_shadow;

    localparam int AW = 9, DW = 8, MIN_PULSE = 4, SAVE_HOLD = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, supply_ok = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, nv_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe, busy;

    int total = 0, bad = 0;
    int n;

    always #2.5 clk = ~clk;

    nvsram_shadow #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE), .SAVE_HOLD(SAVE_HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ce_n(ce_n), .we_n(we_n), .nv_n(nv_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy)
    );

    function automatic logic [7:0] pat1(int a); return 8'((a * 37 + 11) & 255); endfunction
    function automatic logic [7:0] pat2(int a); return 8'(((a * 5 + 200) & 255) ^ 8'h5A); endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ctl(input logic [3:0] c);   // {ce_n,we_n,nv_n,oe_n}
        {ce_n, we_n, nv_n, oe_n} = c;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; ctl(4'b0011);
        @(negedge clk);
        ctl(4'b1111);
    endtask

    task automatic rd_chk(input int a, input logic [7:0] e, input string req);
        @(negedge clk);
        addr = AW'(a); ctl(4'b0110);
        #1;
        chk(rdata_oe && rdata == e, req, rdata_oe ? int'(rdata) : -1, int'(e));
        ctl(4'b1111);
    endtask

    // hold a combination for k rising edges, release at the falling edge after the k-th
    task automatic strobe(input logic [3:0] c, input int k);
        @(negedge clk);
        ctl(c);
        repeat (k) @(negedge clk);
        ctl(4'b1111);
    endtask

    // count busy from the current falling edge onward
    task automatic count_busy(output int cnt);
        cnt = 0;
        while (busy && cnt < 4 * DEPTH) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int errs;
        repeat (3) @(negedge clk);
        chk(busy == 0 && rdata_oe == 0, "reset R9", int'({busy, rdata_oe}), 0);
        rst_n = 1'b1;
        // R9: supply low inhibits reads
        @(negedge clk); ctl(4'b0110); #1;
        chk(rdata_oe == 0 && busy == 0, "R9 no supply", int'({busy, rdata_oe}), 0);
        // R9: supply rises while controls request a write: restore regardless
        ctl(4'b0011);
        supply_ok = 1'b1;
        @(negedge clk);
        ctl(4'b1111);
        count_busy(n);
        chk(n == DEPTH, "R9 power-up restore length", n, DEPTH);

        // R2/R6/R7/R11: sweep all 16 combinations, each held one edge
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            addr = '0; wdata = 8'h00;
            ctl(4'(c)); #1;
            chk(rdata_oe == (c == 4'b0110), "R2 drive decode", int'(rdata_oe), int'(c == 4'b0110));
            @(negedge clk);
            chk(busy == 0, "R7/R11 single-edge combo starts nothing", int'(busy), 0);
            ctl(4'b1111);
        end

        // R1/R2: fill and read back all locations
        for (int a = 0; a < DEPTH; a++) wr(a, pat1(a));
        errs = 0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); addr = AW'(a); ctl(4'b0110); #1;
            if (!(rdata_oe && rdata == pat1(a))) errs++;
        end
        ctl(4'b1111);
        chk(errs == 0, "R1 R2 full readback", errs, 0);
        rd_chk(DEPTH - 1, pat1(DEPTH - 1), "R1 top address");

        // R7: save combination one edge too short
        strobe(4'b0001, MIN_PULSE - 1);
        chk(busy == 0, "R7 short save", int'(busy), 0);
        // R4: accepted save
        strobe(4'b0001, MIN_PULSE);
        count_busy(n);
        chk(n == DEPTH + SAVE_HOLD, "R4 save length", n, DEPTH + SAVE_HOLD);
        // R5: second save with no write in between
        strobe(4'b0001, MIN_PULSE);
        chk(busy == 0, "R5 save without write", int'(busy), 0);

        // overwrite working array with a second pattern
        for (int a = 0; a < DEPTH; a++) wr(a, pat2(a));
        // R6: forbidden combination: no write, no transfer
        @(negedge clk); addr = AW'(3); wdata = ~pat2(3);
        strobe(4'b0000, 2 * MIN_PULSE);
        chk(busy == 0, "R6 forbidden combo no transfer", int'(busy), 0);
        rd_chk(3, pat2(3), "R6 forbidden combo no write");
        // R11: no-op combination
        strobe(4'b0101, 2 * MIN_PULSE);
        chk(busy == 0, "R11 no-op", int'(busy), 0);
        rd_chk(4, pat2(4), "R11 no-op keeps data");
        // R7: short restore
        strobe(4'b0100, MIN_PULSE - 1);
        chk(busy == 0, "R7 short restore", int'(busy), 0);
        rd_chk(5, pat2(5), "R7 data unchanged");

        // R3/R8: restore strobe held well beyond one transfer
        @(negedge clk); ctl(4'b0100);
        n = 0;
        for (int i = 0; i < MIN_PULSE + DEPTH + 40; i++) begin
            @(negedge clk);
            if (busy) n++;
        end
        ctl(4'b1111);
        chk(n == DEPTH, "R3 R8 single restore while held", n, DEPTH);
        errs = 0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); addr = AW'(a); ctl(4'b0110); #1;
            if (!(rdata_oe && rdata == pat1(a))) errs++;
        end
        ctl(4'b1111);
        chk(errs == 0, "R3 restored contents", errs, 0);

        // R10: writes and reads during a transfer
        wr(9, ~pat1(9));
        strobe(4'b0100, MIN_PULSE);
        chk(busy == 1, "R10 transfer started", int'(busy), 1);
        @(negedge clk); addr = AW'(9); wdata = 8'h77; ctl(4'b0011);
        repeat (4) @(negedge clk);
        ctl(4'b0110); #1;
        chk(rdata_oe == 0, "R10 no drive while busy", int'(rdata_oe), 0);
        ctl(4'b1111);
        count_busy(n);
        rd_chk(9, pat1(9), "R10 write during busy dropped");

        // R9: supply loss and automatic restore
        wr(20, 8'h12);
        @(negedge clk); supply_ok = 1'b0;
        @(negedge clk); addr = AW'(21); wdata = 8'h34; ctl(4'b0011);
        @(negedge clk); ctl(4'b0110); #1;
        chk(busy == 0 && rdata_oe == 0, "R9 off inhibited", int'({busy, rdata_oe}), 0);
        ctl(4'b0100);
        supply_ok = 1'b1;
        @(negedge clk);
        ctl(4'b1111);
        count_busy(n);
        chk(n == DEPTH, "R9 supply rise restore length", n, DEPTH);
        rd_chk(20, pat1(20), "R9 shadow survived supply loss");
        rd_chk(21, pat1(21), "R9 write while off dropped");
        // R5: pending-write flag cleared by power-up
        strobe(4'b0001, MIN_PULSE);
        chk(busy == 0, "R5 save refused after power-up", int'(busy), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule